// File: doc/BRIEF.md
# DCO Tuning Word Stepper

This block holds the control word of a digitally controlled oscillator. Each clock cycle a loop controller may ask it to move the word up or down by one least-significant step, or to replace the whole word at once. The word is a chain of six fields. From finest to coarsest they are fine4, fine3, fine2, fine1, coarse and range. A step lands on the finest field. When that field is already at its limit, the step ripples into the next coarser field, so the delay cells see a smooth monotonic progression.

Alongside the packed word, the block decodes the fields into the buses that switch the delay cells. The coarse field appears as a multiplexer select, with a thermometer enable bus for the coarse chain. Each of the four fine fields appears as its own thermometer bus. All outputs come from registers that share one clock edge, so the word and its decoded buses never disagree. At either end of the range a step is refused, and a one-cycle flag reports this.

Top module: `dco_word_stepper`

## Requirements
- R1: While `rst` is high at a rising edge, the word, every decoded bus and `sat_o` become zero.
- R2: With `step_up_i` high and `step_dn_i`, `load_i` low, the 28-bit word advances by one. The field layout is fine4 bits 2:0, fine3 bits 4:3, fine2 bits 9:5, fine1 bits 12:10, coarse bits 18:13 and range bits 27:19. A field at its maximum clears to zero and passes a carry to the next coarser field.
- R3: With `step_dn_i` high and `step_up_i`, `load_i` low, the word goes back by one. A field at zero becomes its maximum and passes a borrow to the next coarser field.
- R4: An up step at the all-ones word and a down step at the all-zeros word leave the word unchanged and set `sat_o` high for one cycle. Every other cycle leaves `sat_o` low.
- R5: With both step inputs high and `load_i` low, the word does not change and `sat_o` stays low.
- R6: With `load_i` high, the word becomes `load_word_i` at the next edge, whatever the step inputs are, and `sat_o` is low.
- R7: `coarse_sel_o` equals word bits 18:13. `chain_en_o` (31 bits) has its lowest N bits set and the rest clear, where N is the coarse field shifted right by one.
- R8: A fine field of value v drives its thermometer bus with the lowest v bits set and the rest clear. The buses are fine1 on 7 bits, fine2 on 31 bits, fine3 on 3 bits and fine4 on 7 bits.
- R9: The word and every decoded bus change on the same clock edge, one edge after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_up_i | input | 1 | Request one step up |
| step_dn_i | input | 1 | Request one step down |
| load_i | input | 1 | Replace the word |
| load_word_i | input | 28 | Word to load |
| word_o | output | 28 | Current tuning word |
| coarse_sel_o | output | 6 | Coarse multiplexer select |
| chain_en_o | output | 31 | Coarse chain enable thermometer |
| fine1_o | output | 7 | Fine1 thermometer |
| fine2_o | output | 31 | Fine2 thermometer |
| fine3_o | output | 3 | Fine3 thermometer |
| fine4_o | output | 7 | Fine4 thermometer |
| sat_o | output | 1 | Step refused at a range end |

## Verification
The assertions assume that the command inputs are synchronous to `clk` and hold a known value at every edge once reset has been released. They also assume that a load carries a full 28-bit word. The stimulus meets both assumptions: it changes every input only at the falling edge and never leaves one undriven. The stimulus loads words that sit just below a carry boundary in every field, and loads both range ends. It then mixes random steps with random loads, which reaches carries, borrows, cancelled steps and saturation in many contexts.

// File: rtl/dco_step_pkg.sv
package dco_step_pkg;
  localparam int DEF_W_RANGE = 9;
  localparam int DEF_W_CRS   = 6;
  localparam int DEF_W_F1    = 3;
  localparam int DEF_W_F2    = 5;
  localparam int DEF_W_F3    = 2;
  localparam int DEF_W_F4    = 3;
  localparam int NSEG        = 6;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_UP   = 2'd1,
    CMD_DN   = 2'd2,
    CMD_LOAD = 2'd3
  } step_cmd_t;
endpackage

// File: rtl/dco_seg_step.sv
module dco_seg_step #(
  parameter int W = 3
) (
  input  logic [W-1:0] val_i,
  input  logic         cin_i,
  input  logic         bin_i,
  output logic [W-1:0] val_o,
  output logic         cout_o,
  output logic         bout_o
);
  logic is_max, is_min;

  assign is_max = &val_i;
  assign is_min = ~|val_i;

  always_comb begin
    if (cin_i)      val_o = val_i + W'(1);
    else if (bin_i) val_o = val_i - W'(1);
    else            val_o = val_i;
  end

  assign cout_o = cin_i & is_max;
  assign bout_o = bin_i & is_min;
endmodule

// File: rtl/dco_therm_dec.sv
module dco_therm_dec #(
  parameter  int CW = 3,
  localparam int NW = (1 << CW) - 1
) (
  input  logic [CW-1:0] cnt_i,
  output logic [NW-1:0] bus_o
);
  for (genvar k = 0; k < NW; k++) begin : g_bit
    assign bus_o[k] = (cnt_i > CW'(k));
  end
endmodule

// File: rtl/dco_word_stepper.sv
module dco_word_stepper
  import dco_step_pkg::*;
#(
  parameter  int W_RANGE = DEF_W_RANGE,
  parameter  int W_CRS   = DEF_W_CRS,
  parameter  int W_F1    = DEF_W_F1,
  parameter  int W_F2    = DEF_W_F2,
  parameter  int W_F3    = DEF_W_F3,
  parameter  int W_F4    = DEF_W_F4,
  localparam int WORD_W  = W_RANGE + W_CRS + W_F1 + W_F2 + W_F3 + W_F4,
  localparam int CH_W    = (1 << (W_CRS - 1)) - 1,
  localparam int F1_N    = (1 << W_F1) - 1,
  localparam int F2_N    = (1 << W_F2) - 1,
  localparam int F3_N    = (1 << W_F3) - 1,
  localparam int F4_N    = (1 << W_F4) - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_up_i,
  input  logic              step_dn_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic [WORD_W-1:0] word_o,
  output logic [W_CRS-1:0]  coarse_sel_o,
  output logic [CH_W-1:0]   chain_en_o,
  output logic [F1_N-1:0]   fine1_o,
  output logic [F2_N-1:0]   fine2_o,
  output logic [F3_N-1:0]   fine3_o,
  output logic [F4_N-1:0]   fine4_o,
  output logic              sat_o
);
  localparam int LO_F3    = W_F4;
  localparam int LO_F2    = LO_F3 + W_F3;
  localparam int LO_F1    = LO_F2 + W_F2;
  localparam int LO_CRS   = LO_F1 + W_F1;
  localparam int LO_RANGE = LO_CRS + W_CRS;

  logic [WORD_W-1:0] word_q, word_step, word_d;
  logic [NSEG:0]     cry, brw;
  logic              at_top, at_bot, sat_d;
  step_cmd_t         cmd;

  logic [CH_W-1:0] chain_d, chain_q;
  logic [F1_N-1:0] f1_d, f1_q;
  logic [F2_N-1:0] f2_d, f2_q;
  logic [F3_N-1:0] f3_d, f3_q;
  logic [F4_N-1:0] f4_d, f4_q;

  always_comb begin
    if (load_i)                     cmd = CMD_LOAD;
    else if (step_up_i && !step_dn_i) cmd = CMD_UP;
    else if (step_dn_i && !step_up_i) cmd = CMD_DN;
    else                            cmd = CMD_HOLD;
  end

  assign at_top = &word_q;
  assign at_bot = ~|word_q;
  assign cry[0] = (cmd == CMD_UP) && !at_top;
  assign brw[0] = (cmd == CMD_DN) && !at_bot;
  assign sat_d  = ((cmd == CMD_UP) && at_top) || ((cmd == CMD_DN) && at_bot);

  // Segment chain, finest first; carries and borrows ripple upward.
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam int SW = (i == 0) ? W_F4 : (i == 1) ? W_F3 : (i == 2) ? W_F2 :
                        (i == 3) ? W_F1 : (i == 4) ? W_CRS : W_RANGE;
    localparam int SL = (i == 0) ? 0 : (i == 1) ? LO_F3 : (i == 2) ? LO_F2 :
                        (i == 3) ? LO_F1 : (i == 4) ? LO_CRS : LO_RANGE;
    dco_seg_step #(.W(SW)) i_seg (
      .val_i  (word_q[SL +: SW]),
      .cin_i  (cry[i]),
      .bin_i  (brw[i]),
      .val_o  (word_step[SL +: SW]),
      .cout_o (cry[i+1]),
      .bout_o (brw[i+1])
    );
  end

  assign word_d = (cmd == CMD_LOAD) ? load_word_i : word_step;

  dco_therm_dec #(.CW(W_CRS-1)) i_chain (.cnt_i(word_d[LO_CRS+1 +: W_CRS-1]), .bus_o(chain_d));
  dco_therm_dec #(.CW(W_F1))    i_f1    (.cnt_i(word_d[LO_F1 +: W_F1]),       .bus_o(f1_d));
  dco_therm_dec #(.CW(W_F2))    i_f2    (.cnt_i(word_d[LO_F2 +: W_F2]),       .bus_o(f2_d));
  dco_therm_dec #(.CW(W_F3))    i_f3    (.cnt_i(word_d[LO_F3 +: W_F3]),       .bus_o(f3_d));
  dco_therm_dec #(.CW(W_F4))    i_f4    (.cnt_i(word_d[0 +: W_F4]),           .bus_o(f4_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q  <= '0;
      chain_q <= '0;
      f1_q    <= '0;
      f2_q    <= '0;
      f3_q    <= '0;
      f4_q    <= '0;
      sat_o   <= 1'b0;
    end else begin
      word_q  <= word_d;
      chain_q <= chain_d;
      f1_q    <= f1_d;
      f2_q    <= f2_d;
      f3_q    <= f3_d;
      f4_q    <= f4_d;
      sat_o   <= sat_d;
    end
  end

  assign word_o       = word_q;
  assign coarse_sel_o = word_q[LO_CRS +: W_CRS];
  assign chain_en_o   = chain_q;
  assign fine1_o      = f1_q;
  assign fine2_o      = f2_q;
  assign fine3_o      = f3_q;
  assign fine4_o      = f4_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (word_o == $past(load_word_i)) && !sat_o); // R6
  AST_CANCEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_up_i && step_dn_i) |=> $stable(word_o) && !sat_o); // R5
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_up_i && !step_dn_i && (&word_o)) |=> sat_o && $stable(word_o)); // R4
  AST_SAT_BOT: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_dn_i && !step_up_i && !(|word_o)) |=> sat_o && $stable(word_o)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !cry[NSEG] && !brw[NSEG]); // R4
  AST_UP_FINEST: assert property (@(posedge clk) disable iff (rst)
    cry[0] |=> word_o[W_F4-1:0] == W_F4'($past(word_o[W_F4-1:0]) + 1'b1)); // R2
  AST_CARRY_COARSE: assert property (@(posedge clk) disable iff (rst)
    cry[4] |=> coarse_sel_o == W_CRS'($past(coarse_sel_o) + 1'b1)); // R2
  AST_BORROW_FILL: assert property (@(posedge clk) disable iff (rst)
    brw[1] |=> (&word_o[W_F4-1:0])); // R3
  AST_CHAIN_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(chain_en_o) == int'(word_o[LO_CRS+1 +: W_CRS-1])); // R7
  AST_FINE2_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(fine2_o) == int'(word_o[LO_F2 +: W_F2])); // R8
endmodule

// File: tb/test_dco_word_stepper.sv
module test_dco_word_stepper;
  localparam longint WMAX = (longint'(1) << 28) - 1;

  logic        clk = 1'b0;
  logic        rst;
  logic        up, dn, ld;
  logic [27:0] lw;
  logic [27:0] word;
  logic [5:0]  csel;
  logic [30:0] chain;
  logic [6:0]  f1;
  logic [30:0] f2;
  logic [2:0]  f3;
  logic [6:0]  f4;
  logic        sat;

  int     n_run  = 0;
  int     n_fail = 0;
  longint mdl    = 0;
  bit     msat   = 0;

  always #5 clk = ~clk;

  dco_word_stepper i_dco_word_stepper (
    .clk(clk), .rst(rst), .step_up_i(up), .step_dn_i(dn), .load_i(ld),
    .load_word_i(lw), .word_o(word), .coarse_sel_o(csel), .chain_en_o(chain),
    .fine1_o(f1), .fine2_o(f2), .fine3_o(f3), .fine4_o(f4), .sat_o(sat)
  );

  function automatic longint ones(longint n);
    return (longint'(1) << n) - 1;
  endfunction

  function automatic longint fld(longint w, int lo, int wd);
    return (w >> lo) & ones(wd);
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag,  "word",     longint'(word),  mdl);
    chk("R4", "sat",      longint'(sat),   longint'(msat));
    chk("R7", "coarse",   longint'(csel),  fld(mdl, 13, 6));
    chk("R7", "chain_en", longint'(chain), ones(fld(mdl, 14, 5)));
    chk("R8", "fine1",    longint'(f1),    ones(fld(mdl, 10, 3)));
    chk("R8", "fine2",    longint'(f2),    ones(fld(mdl, 5, 5)));
    chk("R8", "fine3",    longint'(f3),    ones(fld(mdl, 3, 2)));
    chk("R8", "fine4",    longint'(f4),    ones(fld(mdl, 0, 3)));
    chk("R9", "buses follow word in same cycle",
        longint'((f4 == 7'(ones(word[2:0]))) && (f1 == 7'(ones(word[12:10])))), 1);
  endtask

  // Called at a falling edge; applies one command and checks one cycle later.
  task automatic drive(bit u, bit d, bit l, longint val);
    string tag;
    up = u; dn = d; ld = l; lw = 28'(val);
    @(posedge clk);
    if (l) begin
      mdl = val & WMAX; msat = 0; tag = "R6";
    end else if (u && !d) begin
      tag = "R2";
      if (mdl == WMAX) msat = 1; else begin mdl = mdl + 1; msat = 0; end
    end else if (d && !u) begin
      tag = "R3";
      if (mdl == 0) msat = 1; else begin mdl = mdl - 1; msat = 0; end
    end else begin
      msat = 0; tag = "R5";
    end
    @(negedge clk);
    up = 0; dn = 0; ld = 0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1; up = 0; dn = 0; ld = 0; lw = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check_all("R1");

    // R2: plain counting through fine4/fine3 carries
    for (int i = 0; i < 40; i++) drive(1, 0, 0, 0);
    // R2: carry out of all fine fields into coarse
    drive(0, 0, 1, 28'h0001FFF);
    drive(1, 0, 0, 0);
    // R2: carry from coarse into range field
    drive(0, 0, 1, 28'h007FFFF);
    drive(1, 0, 0, 0);
    // R3: borrow back down through all lower fields
    for (int i = 0; i < 10; i++) drive(0, 1, 0, 0);
    // R4: ends of the range
    drive(0, 0, 1, 0);
    drive(0, 1, 0, 0);
    drive(0, 1, 0, 0);
    drive(1, 0, 0, 0);
    drive(0, 0, 1, WMAX);
    drive(1, 0, 0, 0);
    drive(0, 1, 0, 0);
    drive(1, 0, 0, 0);
    drive(1, 0, 0, 0);
    // R5: simultaneous steps cancel, including at both ends
    drive(1, 1, 0, 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 1, 0);
    drive(1, 1, 0, 0);
    // R6: load wins over step requests
    drive(1, 0, 1, 28'h5A5A5A5);
    drive(0, 1, 1, 28'h0000000);
    // R7: coarse values 62, 63 and 1
    drive(0, 0, 1, 28'h007C000);
    drive(0, 0, 1, 28'h007E000);
    drive(0, 0, 1, 28'h0002000);

    for (int i = 0; i < 600; i++) begin
      int sel = $urandom_range(0, 9);
      if (sel == 0)      drive(0, 0, 1, longint'($urandom()) & WMAX);
      else if (sel == 1) drive(0, 0, 1, (longint'($urandom_range(0, 3)) == 0) ? WMAX - 2 : 2);
      else if (sel < 5)  drive(1, 0, 0, 0);
      else if (sel < 8)  drive(0, 1, 0, 0);
      else if (sel == 8) drive(1, 1, 0, 0);
      else               drive(0, 0, 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule